// File: doc/BRIEF.md
# Framed SPI Master with Frame Sync Pulse

This block is an SPI master that moves one parallel word per transfer. A host hands it a word over a valid/ready handshake; the block shifts the word out most significant bit first on MOSI while capturing MISO, and then presents the received word with a one-cycle done strobe. The serial clock idles low. MOSI changes while SCK is low, and both ends sample on the rising SCK edge. The SCK rate comes from a divider input that is captured when each word is accepted.

The slave-select pin serves two purposes. In plain mode it is held low for the whole word. In framed mode it carries a frame sync pulse that lasts exactly one SCK period and marks the start of each word. Framed mode has two more controls. The pulse polarity can be active high, or active low so that the idle level is high and the pulse goes low. The pulse placement can be an extra SCK period ahead of the first data bit, or the same SCK period as the first data bit.

Top module: `fsync_spi_master`

## Requirements
- R1: After reset, tx_ready is 1, sck is 0, mosi is 0 and rx_done is 0. ss sits at its idle level: 1 in plain mode, and the inverse of cfg_sync_pol in framed mode.
- R2: Each SCK period lasts 2*(cfg_div+1) system clocks and its high half lasts cfg_div+1 clocks. cfg_div is captured when a word is accepted, so a change during a transfer has no effect on that transfer.
- R3: Data leaves on mosi most significant bit first. mosi changes only while sck is low, so it is stable at every rising sck edge.
- R4: miso is sampled at each rising sck edge of a data bit, first bit into the most significant position, and the assembled word appears on rx_data.
- R5: rx_done is high for exactly one system clock per word. It rises one system clock after the edge that samples the last bit, and rx_data carries the received word from then until the next rx_done.
- R6: With cfg_framed=0, ss is low from the accepting edge to the end of the last SCK period, WORD_W*2*(cfg_div+1) clocks, and high at all other times.
- R7: With cfg_framed=1, ss is at its active level for exactly one SCK period, 2*(cfg_div+1) clocks, per word, and that period contains exactly one rising sck edge.
- R8: cfg_sync_pol=1 makes the pulse high on a low idle level. cfg_sync_pol=0 makes the pulse low on a high idle level.
- R9: With cfg_framed=1 and cfg_sync_early=1, the pulse fills an extra leading SCK period, the first data bit follows in the next period, and the word takes WORD_W+1 SCK periods. With cfg_sync_early=0, or in plain mode, the pulse (if any) shares the period of the first data bit and the word takes WORD_W periods.
- R10: tx_ready is 1 only while idle. A word is accepted on a clock edge with tx_valid and tx_ready both 1. tx_valid and tx_data during a transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_framed | input | 1 | 1 selects framed mode (sync pulse on ss) |
| cfg_sync_pol | input | 1 | Sync pulse level: 1 high, 0 low |
| cfg_sync_early | input | 1 | 1 places the pulse one SCK period before the first data bit |
| cfg_div | input | DIV_W | SCK half period minus one, in system clocks |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Block is idle and takes a word |
| tx_data | input | WORD_W | Word to transmit |
| rx_done | output | 1 | One-clock strobe: received word valid |
| rx_data | output | WORD_W | Last received word |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 1 | Slave select / frame sync |

## Verification
The assertions assume that the configuration inputs matter only at the accepting edge. They also assume that miso is stable around each rising sck edge. The bench sets the configuration one clock before it raises tx_valid. Its slave model moves miso half a system clock after each rising sck edge, which is at least one clock before the next sample. It raises tx_valid again during a transfer, and changes cfg_div during a transfer, only to show that both are ignored. The pulse polarity and the framed setting stay fixed while a word is in flight, so the bench can tell which ss level is active.

// File: rtl/fsm_pkg.sv
package fsm_pkg;
    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_RUN  = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/fsm_baud_tick.sv
module fsm_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t bd_d, bd_q;

    always_comb begin
        bd_d = bd_q;
        if (!run)
            bd_d.cnt = '0;
        else if (bd_q.cnt == div)
            bd_d.cnt = '0;
        else
            bd_d.cnt = bd_q.cnt + 1'b1;
    end

    assign tick = run && (bd_q.cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bd_q <= '0;
        else        bd_q <= bd_d;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bd_q.cnt <= div));
endmodule

// File: rtl/fsm_shift_core.sv
module fsm_shift_core #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              shift_tx,
    input  logic              sample,
    input  logic              miso,
    output logic              tx_msb,
    output logic [WORD_W-1:0] rx_word
);
    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d.tx = load_data;
        else if (shift_tx)
            sh_d.tx = {sh_q.tx[WORD_W-2:0], 1'b0};
        if (sample)
            sh_d.rx = {sh_q.rx[WORD_W-2:0], miso};
    end

    assign tx_msb  = sh_q.tx[WORD_W-1];
    assign rx_word = sh_q.rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R4
    no_load_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && sample));
endmodule

// File: rtl/fsm_sync_gen.sv
module fsm_sync_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             first_slot,
    input  logic             framed_lat,
    input  logic             pol_lat,
    input  logic             framed_cfg,
    input  logic             pol_cfg,
    input  logic [DIV_W-1:0] div_lat,
    output logic             ss
);
    localparam int CW = DIV_W + 2;

    logic sync_on;

    assign sync_on = busy && framed_lat && first_slot;

    always_comb begin
        if (busy)
            ss = framed_lat ? (sync_on ? pol_lat : !pol_lat) : 1'b0;
        else
            ss = framed_cfg ? !pol_cfg : 1'b1;
    end

    // checker state: length of the current sync pulse in system clocks
    logic [CW-1:0] len_d, len_q;
    logic [CW-1:0] exp_len;

    assign exp_len = (CW'(div_lat) + CW'(1)) << 1;

    always_comb begin
        len_d = sync_on ? len_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    // R7
    sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_on) |-> (len_q == exp_len));
endmodule

// File: rtl/fsync_spi_master.sv
module fsync_spi_master
    import fsm_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_framed,
    input  logic              cfg_sync_pol,
    input  logic              cfg_sync_early,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_data,
    output logic              rx_done,
    output logic [WORD_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss
);
    localparam int SLOT_W = $clog2(WORD_W + 2);
    localparam logic [SLOT_W-1:0] LAST_ALIGNED = SLOT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_EARLY   = SLOT_W'(WORD_W);

    typedef struct packed {
        xfer_state_e       st;
        logic [SLOT_W-1:0] slot;
        logic              phase;
        logic              framed;
        logic              pol;
        logic              early;
        logic [DIV_W-1:0]  div;
        logic              last_smp;
        logic              done;
        logic [WORD_W-1:0] rx_out;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              busy, tick, accept, pre, data_slot;
    logic              sample_en, shift_en;
    logic [SLOT_W-1:0] last_slot;
    logic              tx_msb;
    logic [WORD_W-1:0] rx_word;

    assign busy      = (c_q.st == XF_RUN);
    assign accept    = !busy && tx_valid;
    assign pre       = c_q.framed && c_q.early;
    assign last_slot = pre ? LAST_EARLY : LAST_ALIGNED;
    assign data_slot = !(pre && (c_q.slot == '0));
    assign sample_en = busy && tick && !c_q.phase && data_slot;
    assign shift_en  = busy && tick && c_q.phase && data_slot;

    always_comb begin
        c_d          = c_q;
        c_d.done     = 1'b0;
        c_d.last_smp = 1'b0;
        if (accept) begin
            c_d.st     = XF_RUN;
            c_d.slot   = '0;
            c_d.phase  = 1'b0;
            c_d.framed = cfg_framed;
            c_d.pol    = cfg_sync_pol;
            c_d.early  = cfg_sync_early;
            c_d.div    = cfg_div;
        end else if (busy && tick) begin
            if (!c_q.phase) begin
                c_d.phase    = 1'b1;
                c_d.last_smp = data_slot && (c_q.slot == last_slot);
            end else begin
                c_d.phase = 1'b0;
                if (c_q.slot == last_slot)
                    c_d.st = XF_IDLE;
                else
                    c_d.slot = c_q.slot + 1'b1;
            end
        end
        if (c_q.last_smp) begin
            c_d.done   = 1'b1;
            c_d.rx_out = rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    fsm_baud_tick #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (c_q.div),
        .tick (tick)
    );

    fsm_shift_core #(.WORD_W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(tx_data),
        .shift_tx (shift_en),
        .sample   (sample_en),
        .miso     (miso),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    fsm_sync_gen #(.DIV_W(DIV_W)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .first_slot(c_q.slot == '0),
        .framed_lat(c_q.framed),
        .pol_lat   (c_q.pol),
        .framed_cfg(cfg_framed),
        .pol_cfg   (cfg_sync_pol),
        .div_lat   (c_q.div),
        .ss        (ss)
    );

    assign tx_ready = !busy;
    assign sck      = busy && c_q.phase;
    assign mosi     = busy ? tx_msb : 1'b0;
    assign rx_done  = c_q.done;
    assign rx_data  = c_q.rx_out;

    // R2
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sck));

    // R3
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sck) && sck) |-> $stable(mosi));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: tb/fsync_spi_master_tb_top.sv
`timescale 1ns/1ps
module fsync_spi_master_tb_top;
    localparam int W  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_framed = 1'b1, cfg_sync_pol = 1'b0, cfg_sync_early = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [W-1:0]  tx_data = '0;
    logic          rx_done;
    logic [W-1:0]  rx_data;
    logic          sck, mosi, ss;
    logic          miso = 1'b0;

    always #5 clk = ~clk;

    fsync_spi_master #(.WORD_W(W), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_framed(cfg_framed), .cfg_sync_pol(cfg_sync_pol),
        .cfg_sync_early(cfg_sync_early), .cfg_div(cfg_div),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_done(rx_done), .rx_data(rx_data),
        .sck(sck), .mosi(mosi), .miso(miso), .ss(ss)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // monitor and slave model
    logic [W-1:0] reply = '0;
    logic [W-1:0] mosi_word = '0;
    logic [W-1:0] rx_seen = '0;
    int rise_tot = 0, rise_out = 0, sck_hi = 0, ss_act = 0, done_cnt = 0;
    int gap = 0, done_gap = 0, slv_idx = 0;
    logic prev_sck = 1'b0, prev_rdy = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic act_lvl;
            int   pre;
            act_lvl = cfg_framed ? cfg_sync_pol : 1'b0;
            pre = (cfg_framed && cfg_sync_early) ? 1 : 0;
            if (ss == act_lvl) ss_act++;
            if (sck) sck_hi++;
            if (prev_rdy && !tx_ready) begin
                slv_idx   = 0;
                mosi_word = '0;
                miso      = reply[W-1];
            end
            if (sck && !prev_sck) begin
                rise_tot++;
                if (ss != act_lvl) rise_out++;
                gap = 0;
                if (slv_idx >= pre) begin
                    int k;
                    k = slv_idx - pre;
                    mosi_word = {mosi_word[W-2:0], mosi};
                    miso = (k + 1 < W) ? reply[W-2-k] : 1'b0;
                end
                slv_idx++;
            end else begin
                gap++;
            end
            if (rx_done) begin
                done_cnt++;
                done_gap = gap;
                rx_seen  = rx_data;
            end
            prev_sck = sck;
            prev_rdy = tx_ready;
        end
    end

    task automatic xfer(input int div, input bit fr, input bit pol, input bit early,
                        input logic [W-1:0] word, input logic [W-1:0] rep, input bit junk);
        int s_rise, s_out, s_hi, s_ss, s_done, h, s, exp_ss, guard;
        @(negedge clk);
        cfg_div = DW'(div); cfg_framed = fr; cfg_sync_pol = pol; cfg_sync_early = early;
        reply = rep; tx_data = word;
        @(negedge clk); #1;
        s_rise = rise_tot; s_out = rise_out; s_hi = sck_hi; s_ss = ss_act; s_done = done_cnt;
        tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R10 busy after accept", tx_ready, 0);
        if (junk) begin
            // R10: offers during a transfer are ignored; R2: divider change ignored
            tx_valid = 1'b1; tx_data = ~word; cfg_div = DW'(div + 3);
            repeat (6) @(negedge clk);
            chk(tx_ready == 1'b0, "R10 still busy", tx_ready, 0);
            tx_valid = 1'b0; tx_data = word;
        end
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tx_ready && guard < 20000);
        repeat (4) @(negedge clk);
        #1;
        h = div + 1;
        s = W + ((fr && early) ? 1 : 0);
        exp_ss = fr ? 2 * h : 2 * h * W;
        chk(rise_tot - s_rise == s, "R9 sck periods per word", rise_tot - s_rise, s);
        chk(sck_hi - s_hi == h * s, "R2 sck high clocks", sck_hi - s_hi, h * s);
        if (fr) begin
            chk(ss_act - s_ss == exp_ss, "R7 sync pulse clocks", ss_act - s_ss, exp_ss);
            chk(rise_out - s_out == s - 1, "R7 one rise in pulse", rise_out - s_out, s - 1);
        end else begin
            chk(ss_act - s_ss == exp_ss, "R6 select low clocks", ss_act - s_ss, exp_ss);
            chk(rise_out - s_out == 0, "R6 all rises selected", rise_out - s_out, 0);
        end
        chk(mosi_word == word, "R3 mosi word / R9 placement", mosi_word, word);
        chk(rx_seen == rep, "R4 received word", rx_seen, rep);
        chk(rx_data == rep, "R5 rx_data held", rx_data, rep);
        chk(done_cnt - s_done == 1, "R5 one done per word", done_cnt - s_done, 1);
        chk(done_gap == 1, "R5 done one clock after last sample", done_gap, 1);
        chk(ss == (fr ? !pol : 1'b1), "R8 idle level", ss, fr ? !pol : 1'b1);
        chk(sck == 1'b0 && mosi == 1'b0, "R1 idle lines", {sck, mosi}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state with framed, active-low sync selected
        chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(mosi == 1'b0, "R1 mosi", mosi, 0);
        chk(rx_done == 1'b0, "R1 done", rx_done, 0);
        chk(ss == 1'b1, "R1 ss idle framed low-pol", ss, 1);
        cfg_sync_pol = 1'b1; #1;
        chk(ss == 1'b0, "R8 ss idle framed high-pol", ss, 0);
        cfg_framed = 1'b0; #1;
        chk(ss == 1'b1, "R6 ss idle plain", ss, 1);
        rst_n = 1'b1;
        for (int idx = 0; idx < 24; idx++) begin
            int  d;
            bit  f, p, e;
            d = idx / 8; f = idx[2]; p = idx[1]; e = idx[0];
            xfer(d, f, p, e, 16'hB4C1 ^ W'(idx * 16'h03A5), 16'h5E27 + W'(idx * 16'h01F3), 1'b0);
        end
        xfer(3, 1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0);
        xfer(0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 1'b0);
        xfer(1, 1'b1, 1'b0, 1'b1, 16'h8001, 16'h7FFE, 1'b1);
        xfer(2, 1'b0, 1'b0, 1'b0, 16'h1234, 16'hC3A5, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule